// File: doc/BRIEF.md
# Region-Selectable Bus Clock Phaser

The phaser turns one master clock into the timing strobes that a processor bus and a video unit run on. Every master tick belongs to a position inside a CPU cycle. The CPU cycle is split into a first phase and a second phase. The block marks the first tick of each CPU cycle and the first tick of its second phase. It also produces a separate clock enable for the video unit. Three region timings are built in. Each one fixes the CPU period, the nominal split between the two phases, and the video divider.

The phase boundary is not fixed within the cycle. The caller states whether the coming CPU cycle is a read or a write on the tick where the cycle strobe is high. For a read, the boundary comes one tick earlier than nominal. For a write, it comes one tick later. The CPU period stays the same in both cases.

The region select and the video offset are taken only while reset is held. After reset the master count stands at one CPU period plus a CPU offset, which is a parameter with a default of 0. The video enable fires whenever that count, minus the video offset, is a multiple of the video divider.

Top module: `clkph_top`

## Requirements
- R1: While reset is held, and on the first tick after reset is released, cyc_stb is 1 and mid_stb is 0. This holds with the default CPU offset of 0.
- R2: cyc_stb pulses once every P master ticks. P is 12 for region code 2'b00, 16 for 2'b01 and 15 for 2'b10. Code 2'b11 behaves like 2'b00.
- R3: In a read cycle (is_read = 1), mid_stb pulses F-1 ticks after cyc_stb. F is the nominal first-phase length: 6 for code 00 and 11, 8 for code 01, 7 for code 10.
- R4: In a write cycle (is_read = 0), mid_stb pulses F+1 ticks after cyc_stb.
- R5: The cycle kind is is_read as sampled on the tick where cyc_stb is high. Changes of is_read on any other tick of that cycle do not move mid_stb.
- R6: Number the ticks after reset release t = 0, 1, 2, … Then vid_ce is 1 exactly on the ticks where (P + CPU offset - voff + t) mod V = 0. V is 4 for codes 00 and 11, and 5 for codes 01 and 10.
- R7: Changes of region_sel or voff while reset is low have no effect on cyc_stb, mid_stb or vid_ce.
- R8: cyc_stb and mid_stb are never high on the same tick. Each CPU cycle has exactly one mid_stb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; region and offset are captured while it is high |
| region_sel | input | 2 | Region timing code: 00 and 11 for 12/6/4, 01 for 16/8/5, 10 for 15/7/5 (period/first phase/video divider) |
| is_read | input | 1 | Kind of the CPU cycle that starts on this tick: 1 for a read, 0 for a write |
| voff | input | VOFF_W | Video offset in master ticks, taken during reset |
| cyc_stb | output | 1 | First tick of a CPU cycle |
| mid_stb | output | 1 | First tick of the second phase |
| vid_ce | output | 1 | Video unit clock enable |

## Verification
With the default settings, all three strobes are decoded straight from state registers. The result for tick t is therefore visible during the same master tick, and the first tick after reset release shows the reset values. The bench holds one expected item per tick in a queue and compares it 2 ns after the falling edge. At that point the state has settled and is_read for the tick has already been driven.

The cycle kind is latched on the tick of cyc_stb, but it only shows up at mid_stb five to nine ticks later. The model therefore latches its own copy of the kind on the cycle-start tick and predicts the mid position from that copy. This lets toggling is_read on the other ticks show up as a mismatch. Region and offset changes made after release are followed by several complete periods of comparison against the timing chosen at reset.

// File: rtl/clkph_pkg.sv
package clkph_pkg;

   // Width of every tick position, period and divider value in the block.
   localparam int PH_W = 6;

   typedef logic [PH_W-1:0] ph_t;

   // Region timing codes; the alias code reuses the first timing set.
   typedef enum logic [1:0] {
      RGN_A     = 2'd0,
      RGN_B     = 2'd1,
      RGN_C     = 2'd2,
      RGN_ALIAS = 2'd3
   } region_e;

   // Timing of the currently selected region.
   typedef struct packed {
      ph_t period;
      ph_t first;
      ph_t vdiv;
   } phase_cfg_t;

endpackage

// File: rtl/clkph_region_cfg.sv
module clkph_region_cfg
   import clkph_pkg::*;
#(
   parameter int unsigned RA_FIRST  = 6,
   parameter int unsigned RA_SECOND = 6,
   parameter int unsigned RA_VDIV   = 4,
   parameter int unsigned RB_FIRST  = 8,
   parameter int unsigned RB_SECOND = 8,
   parameter int unsigned RB_VDIV   = 5,
   parameter int unsigned RC_FIRST  = 7,
   parameter int unsigned RC_SECOND = 8,
   parameter int unsigned RC_VDIV   = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] region_sel,
   output phase_cfg_t cur_cfg,
   output ph_t        ld_period,
   output ph_t        ld_vdiv,
   output region_e    region_q
);

   localparam int unsigned RA_PERIOD = RA_FIRST + RA_SECOND;
   localparam int unsigned RB_PERIOD = RB_FIRST + RB_SECOND;
   localparam int unsigned RC_PERIOD = RC_FIRST + RC_SECOND;
   localparam int unsigned PH_LIMIT  = 2 ** PH_W;

   // A read shortens the first phase by one tick and a write lengthens it
   // by one, so both phases need at least two ticks.
   if (RA_FIRST < 2 || RB_FIRST < 2 || RC_FIRST < 2) begin : g_bad_first
      $error("clkph_region_cfg: every first phase must be at least 2 ticks");
   end
   if (RA_SECOND < 2 || RB_SECOND < 2 || RC_SECOND < 2) begin : g_bad_second
      $error("clkph_region_cfg: every second phase must be at least 2 ticks");
   end
   if (RA_PERIOD >= PH_LIMIT || RB_PERIOD >= PH_LIMIT || RC_PERIOD >= PH_LIMIT) begin : g_bad_period
      $error("clkph_region_cfg: a period does not fit the tick width");
   end
   if (RA_VDIV < 1 || RB_VDIV < 1 || RC_VDIV < 1 ||
       RA_VDIV >= PH_LIMIT || RB_VDIV >= PH_LIMIT || RC_VDIV >= PH_LIMIT) begin : g_bad_vdiv
      $error("clkph_region_cfg: video divider out of range");
   end

   function automatic ph_t period_of(region_e r);
      case (r)
         RGN_B:   return ph_t'(RB_PERIOD);
         RGN_C:   return ph_t'(RC_PERIOD);
         default: return ph_t'(RA_PERIOD);
      endcase
   endfunction

   function automatic ph_t first_of(region_e r);
      case (r)
         RGN_B:   return ph_t'(RB_FIRST);
         RGN_C:   return ph_t'(RC_FIRST);
         default: return ph_t'(RA_FIRST);
      endcase
   endfunction

   function automatic ph_t vdiv_of(region_e r);
      case (r)
         RGN_B:   return ph_t'(RB_VDIV);
         RGN_C:   return ph_t'(RC_VDIV);
         default: return ph_t'(RA_VDIV);
      endcase
   endfunction

   region_e sel_e;
   assign sel_e = region_e'(region_sel);

   // The region code is latched only while reset is held.
   always_ff @(posedge clk) begin
      if (rst) begin
         region_q <= sel_e;
      end
   end

   // Timing that applies once reset is released.
   assign cur_cfg.period = period_of(region_q);
   assign cur_cfg.first  = first_of(region_q);
   assign cur_cfg.vdiv   = vdiv_of(region_q);

   // Timing of the code on the input, used for the reset load values.
   assign ld_period = period_of(sel_e);
   assign ld_vdiv   = vdiv_of(sel_e);

endmodule

// File: rtl/clkph_cpu_seq.sv
module clkph_cpu_seq
   import clkph_pkg::*;
#(
   parameter int unsigned CPU_SKEW = 0
) (
   input  logic clk,
   input  logic rst,
   input  ph_t  ld_period,
   input  ph_t  cur_period,
   input  ph_t  cur_first,
   input  logic is_read,
   output logic cyc_raw,
   output logic mid_raw,
   output logic kind
);

   ph_t pos;
   ph_t pos_init;
   ph_t mid_at;
   ph_t last_pos;

   // Position within the CPU cycle for a master count of P + skew.
   assign pos_init = ph_t'(32'(CPU_SKEW) % 32'(ld_period));
   assign last_pos = cur_period - ph_t'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos <= pos_init;
      end else if (pos == last_pos) begin
         pos <= '0;
      end else begin
         pos <= pos + ph_t'(1);
      end
   end

   // The cycle kind is taken on the cycle-start tick and held for the cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         kind <= 1'b1;
      end else if (cyc_raw) begin
         kind <= is_read;
      end
   end

   // A read moves the boundary one tick early; a write moves it one tick late.
   always_comb begin
      if (kind) begin
         mid_at = cur_first - ph_t'(1);
      end else begin
         mid_at = cur_first + ph_t'(1);
      end
   end

   assign cyc_raw = (pos == '0);
   assign mid_raw = (pos == mid_at) && (pos != '0);

endmodule

// File: rtl/clkph_vid_div.sv
module clkph_vid_div
   import clkph_pkg::*;
#(
   parameter int unsigned CPU_SKEW = 0,
   parameter int unsigned VOFF_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  ph_t               ld_period,
   input  ph_t               ld_vdiv,
   input  ph_t               cur_vdiv,
   input  logic [VOFF_W-1:0] voff,
   output logic              vid_raw
);

   ph_t res;
   ph_t res_init;
   ph_t res_last;
   logic [31:0] shifted;

   // Residue of (master count - offset) modulo the divider.  The divider
   // times 2**VOFF_W is added first so that the difference never goes
   // negative, whatever offset is on the input.
   assign shifted  = 32'(ld_period) + 32'(CPU_SKEW) + (32'(ld_vdiv) << VOFF_W) - 32'(voff);
   assign res_init = ph_t'(shifted % 32'(ld_vdiv));
   assign res_last = cur_vdiv - ph_t'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         res <= res_init;
      end else if (res == res_last) begin
         res <= '0;
      end else begin
         res <= res + ph_t'(1);
      end
   end

   assign vid_raw = (res == '0);

endmodule

// File: rtl/clkph_top.sv
module clkph_top
   import clkph_pkg::*;
#(
   parameter int unsigned RA_FIRST  = 6,
   parameter int unsigned RA_SECOND = 6,
   parameter int unsigned RA_VDIV   = 4,
   parameter int unsigned RB_FIRST  = 8,
   parameter int unsigned RB_SECOND = 8,
   parameter int unsigned RB_VDIV   = 5,
   parameter int unsigned RC_FIRST  = 7,
   parameter int unsigned RC_SECOND = 8,
   parameter int unsigned RC_VDIV   = 5,
   parameter int unsigned CPU_SKEW  = 0,
   parameter int unsigned VOFF_W    = 3,
   parameter int unsigned REG_OUT   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        region_sel,
   input  logic              is_read,
   input  logic [VOFF_W-1:0] voff,
   output logic              cyc_stb,
   output logic              mid_stb,
   output logic              vid_ce
);

   if (VOFF_W < 1 || VOFF_W > 8) begin : g_bad_voff
      $error("clkph_top: VOFF_W must be 1 to 8");
   end
   if (REG_OUT > 1) begin : g_bad_regout
      $error("clkph_top: REG_OUT must be 0 or 1");
   end

   phase_cfg_t cur_cfg;
   ph_t        ld_period;
   ph_t        ld_vdiv;
   region_e    region_q;
   ph_t        cur_period;
   ph_t        cur_first;
   ph_t        cur_vdiv;
   logic       cyc_raw;
   logic       mid_raw;
   logic       vid_raw;
   logic       kind;

   clkph_region_cfg #(
      .RA_FIRST (RA_FIRST),
      .RA_SECOND(RA_SECOND),
      .RA_VDIV  (RA_VDIV),
      .RB_FIRST (RB_FIRST),
      .RB_SECOND(RB_SECOND),
      .RB_VDIV  (RB_VDIV),
      .RC_FIRST (RC_FIRST),
      .RC_SECOND(RC_SECOND),
      .RC_VDIV  (RC_VDIV)
   ) u_cfg (
      .clk       (clk),
      .rst       (rst),
      .region_sel(region_sel),
      .cur_cfg   (cur_cfg),
      .ld_period (ld_period),
      .ld_vdiv   (ld_vdiv),
      .region_q  (region_q)
   );

   assign cur_period = cur_cfg.period;
   assign cur_first  = cur_cfg.first;
   assign cur_vdiv   = cur_cfg.vdiv;

   clkph_cpu_seq #(
      .CPU_SKEW(CPU_SKEW)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .ld_period (ld_period),
      .cur_period(cur_period),
      .cur_first (cur_first),
      .is_read   (is_read),
      .cyc_raw   (cyc_raw),
      .mid_raw   (mid_raw),
      .kind      (kind)
   );

   clkph_vid_div #(
      .CPU_SKEW(CPU_SKEW),
      .VOFF_W  (VOFF_W)
   ) u_vid (
      .clk      (clk),
      .rst      (rst),
      .ld_period(ld_period),
      .ld_vdiv  (ld_vdiv),
      .cur_vdiv (cur_vdiv),
      .voff     (voff),
      .vid_raw  (vid_raw)
   );

   // Output variant: decoded straight from state, or through one flop.
   if (REG_OUT != 0) begin : g_out_flop
      always_ff @(posedge clk) begin
         if (rst) begin
            cyc_stb <= 1'b0;
            mid_stb <= 1'b0;
            vid_ce  <= 1'b0;
         end else begin
            cyc_stb <= cyc_raw;
            mid_stb <= mid_raw;
            vid_ce  <= vid_raw;
         end
      end
   end else begin : g_out_direct
      assign cyc_stb = cyc_raw;
      assign mid_stb = mid_raw;
      assign vid_ce  = vid_raw;
   end

endmodule

// File: rtl/clkph_chk.sv
module clkph_chk
   import clkph_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       is_read,
   input logic       cyc_raw,
   input logic       mid_raw,
   input logic       vid_raw,
   input logic       kind,
   input ph_t        cur_period,
   input ph_t        cur_first,
   input ph_t        cur_vdiv,
   input logic [1:0] region_q
);

   ph_t  ccnt;
   ph_t  vcnt;
   logic cseen;
   logic vseen;

   // Tick counters since the last cycle strobe and the last video enable.
   always_ff @(posedge clk) begin
      if (rst) begin
         ccnt  <= '0;
         vcnt  <= '0;
         cseen <= 1'b0;
         vseen <= 1'b0;
      end else begin
         if (cyc_raw) begin
            ccnt  <= ph_t'(1);
            cseen <= 1'b1;
         end else begin
            ccnt <= ccnt + ph_t'(1);
         end
         if (vid_raw) begin
            vcnt  <= ph_t'(1);
            vseen <= 1'b1;
         end else begin
            vcnt <= vcnt + ph_t'(1);
         end
      end
   end

   a_r8_strobes_apart: assert property (@(posedge clk) disable iff (rst)
      !(cyc_raw && mid_raw));

   a_r2_period_gap: assert property (@(posedge clk) disable iff (rst)
      (cseen && cyc_raw) |-> (ccnt == cur_period));

   a_r3_read_mid: assert property (@(posedge clk) disable iff (rst)
      (cseen && mid_raw && kind) |-> (ccnt == cur_first - ph_t'(1)));

   a_r4_write_mid: assert property (@(posedge clk) disable iff (rst)
      (cseen && mid_raw && !kind) |-> (ccnt == cur_first + ph_t'(1)));

   a_r5_kind_capture: assert property (@(posedge clk) disable iff (rst)
      cyc_raw |=> (kind == $past(is_read)));

   a_r6_video_gap: assert property (@(posedge clk) disable iff (rst)
      (vseen && vid_raw) |-> (vcnt == cur_vdiv));

   a_r7_region_hold: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(region_q));

endmodule

bind clkph_top clkph_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .is_read   (is_read),
   .cyc_raw   (cyc_raw),
   .mid_raw   (mid_raw),
   .vid_raw   (vid_raw),
   .kind      (kind),
   .cur_period(cur_period),
   .cur_first (cur_first),
   .cur_vdiv  (cur_vdiv),
   .region_q  (region_q)
);

// File: tb/sim_clkph_top.sv
`timescale 1ns/1ps
module sim_clkph_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] region_sel = 2'd0;
   logic       is_read = 1'b1;
   logic [2:0] voff = 3'd1;
   logic       cyc_stb;
   logic       mid_stb;
   logic       vid_ce;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic  cyc;
      logic  mid;
      logic  vid;
      string ctag;
      string mtag;
      string vtag;
   } exp_t;

   exp_t q[$];

   always #4 clk = ~clk;

   clkph_top u0 (
      .clk       (clk),
      .rst       (rst),
      .region_sel(region_sel),
      .is_read   (is_read),
      .voff      (voff),
      .cyc_stb   (cyc_stb),
      .mid_stb   (mid_stb),
      .vid_ce    (vid_ce)
   );

   function automatic int tb_period(int rg);
      case (rg)
         1: return 16;
         2: return 15;
         default: return 12;
      endcase
   endfunction

   function automatic int tb_first(int rg);
      case (rg)
         1: return 8;
         2: return 7;
         default: return 6;
      endcase
   endfunction

   function automatic int tb_vdiv(int rg);
      case (rg)
         1, 2: return 5;
         default: return 4;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Monitor: one expected item per tick, compared away from the clock edges.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            check(it.ctag, "cyc_stb", cyc_stb, it.cyc);
            check(it.mtag, "mid_stb", mid_stb, it.mid);
            check(it.vtag, "vid_ce", vid_ce, it.vid);
            check("R8", "cyc_stb&mid_stb", cyc_stb & mid_stb, 1'b0);
         end
      end
   end

   // Driver. mode: 0 all reads, 1 all writes, 2 alternating per cycle,
   // 3 is_read toggled on every tick.
   task automatic run_phase(input int rg, input int off, input int ncyc,
                            input int mode, input bit scramble);
      int p;
      int f;
      int v;
      logic k;
      p = tb_period(rg);
      f = tb_first(rg);
      v = tb_vdiv(rg);
      @(negedge clk);
      rst        = 1'b1;
      region_sel = 2'(rg);
      voff       = 3'(off);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      k   = 1'b1;
      for (int t = 0; t < ncyc * p; t++) begin
         exp_t it;
         logic rd;
         case (mode)
            0: rd = 1'b1;
            1: rd = 1'b0;
            2: rd = ((t / p) % 2) == 0;
            default: rd = (t % 2) == 1;
         endcase
         is_read = rd;
         if (t % p == 0) k = rd;
         it.cyc  = (t % p == 0);
         it.mid  = (t % p == (k ? f - 1 : f + 1));
         it.vid  = ((p - off + t) % v == 0);
         it.ctag = (t == 0) ? "R1" : (scramble ? "R7" : "R2");
         it.mtag = (mode == 3) ? "R5" : (scramble ? "R7" : (k ? "R3" : "R4"));
         it.vtag = scramble ? "R7" : "R6";
         q.push_back(it);
         if (scramble && t == 2) begin
            region_sel = 2'((rg + 1) % 4);
            voff       = 3'(off + 3);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      // Reset state (R1): region code 00, offset 1, residue (12-1) mod 4 = 3.
      repeat (2) @(posedge clk);
      @(negedge clk);
      #2;
      check("R1", "cyc_stb in reset", cyc_stb, 1'b1);
      check("R1", "mid_stb in reset", mid_stb, 1'b0);
      check("R6", "vid_ce in reset", vid_ce, 1'b0);

      run_phase(0, 1, 5, 0, 1'b0);   // R2 R3 R6, region 00, reads
      run_phase(0, 1, 5, 1, 1'b0);   // R4, region 00, writes
      run_phase(1, 1, 5, 2, 1'b0);   // R2 R3 R4 R6, region 01
      run_phase(2, 1, 5, 2, 1'b0);   // region 10, alternating kinds
      run_phase(2, 3, 5, 3, 1'b0);   // R5, is_read changes on every tick
      run_phase(2, 1, 5, 0, 1'b1);   // R7, region and offset moved after release
      run_phase(3, 0, 4, 0, 1'b0);   // R2, alias code 11 behaves like 00
      run_phase(1, 0, 4, 1, 1'b0);   // R4 R6, region 01 with offset 0

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(64'd8 * 64'd200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule